// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block is a write-only serial configuration port for a frequency synthesizer. A host drives a serial clock, a data line and a load-enable line. On each serial clock rising edge, one data bit enters a 32-bit shift register, with the most significant bit sent first. On a rising edge of load-enable, the word in the shift register is committed. Its three least significant bits select a destination register, and its upper 29 bits become that register's new contents.

The three serial lines and the active-high chip enable are asynchronous to the block. Each passes through a synchronizer chain clocked by the faster system clock, and the serial edges are detected in that domain. The system clock must therefore run at least four times faster than the serial clock.

Each destination register is presented in parallel together with a one-cycle update strobe, so the downstream logic knows which setting changed. While chip enable is low, the block is in power-down. The stored settings are held at zero, serial activity is ignored, and a registered flag tells the charge-pump control that its output must be three-stated.

Top module: `serial_cfg_loader`

## Requirements
- R1: After a synchronous reset, every destination register reads zero, no update strobe is high and the charge-pump disable flag `pump_hiz` is 1.
- R2: Bits are shifted most significant bit first. When a load is committed, bits 2..0 of the last 32 bits shifted in select the destination register, and bits 31..3 are stored into it. Register i appears on `cfg_regs[i*PAY_W +: PAY_W]`, where PAY_W = WORD_W - ADDR_W.
- R3: A load happens only on a rising edge of `ser_le`. Holding `ser_le` high for any length of time produces exactly one load.
- R4: Each load to register i drives `upd_strobe[i]` high for exactly one system clock cycle. That is the same cycle in which the new value first appears, and at most one strobe bit is ever high.
- R5: Any number of serial bits may arrive between loads. Only the most recent 32 bits are used, so shorter bursts reuse older bits and longer bursts discard the earliest ones.
- R6: A load whose address bits 2..0 are NUM_REGS or greater changes no register and raises no strobe.
- R7: While `chip_en` is low, all registers are held at zero and `pump_hiz` is 1. Serial bits and load edges are ignored, and the shift register is cleared, so after re-enable the unsent upper bits of a word read as zero.
- R8: Without a strobe, a register keeps its value, and a load to one register leaves all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; a bit is taken on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load enable; its rising edge commits the word |
| chip_en | input | 1 | Chip enable; low holds the block in power-down |
| cfg_regs | output | NUM_REGS*(WORD_W-ADDR_W) | Concatenated destination register contents |
| upd_strobe | output | NUM_REGS | One-cycle update pulse per destination register |
| pump_hiz | output | 1 | High while the charge-pump output must be three-stated |

## Verification
The bench builds the block with NUM_REGS = 6, keeping the 32-bit word and the 3-bit address field. With six registers, the address codes 6 and 7 become out-of-range words that must be dropped, which makes R6 reachable. Random bursts of 24 to 40 bits exercise the rule that only the last 32 bits count.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  // Channels carried through the input synchronizer, in vector order.
  typedef enum int {
    CH_DATA = 0,
    CH_SCLK = 1,
    CH_LE   = 2,
    CH_EN   = 3
  } cfgl_chan_e;

  localparam int N_CHAN = 4;
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  // One independent flop chain per input bit.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end

    assign d_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  // New bits enter at the bottom, so the first bit sent ends up at the top.
  always_ff @(posedge clk) begin
    if (rst || clear) word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
  end
endmodule

// File: rtl/cfgl_regbank.sv
module cfgl_regbank #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 3,
  parameter int PAY_W    = 29
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      load,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [PAY_W-1:0]          payload,
  output logic [NUM_REGS*PAY_W-1:0] regs_flat,
  output logic [NUM_REGS-1:0]       strobe
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    logic [PAY_W-1:0] value;

    assign hit = load && (addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        value     <= '0;
        strobe[i] <= 1'b0;
      end else begin
        strobe[i] <= hit;
        if (hit) value <= payload;
      end
    end

    assign regs_flat[i*PAY_W +: PAY_W] = value;
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfgl_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 ser_clk,
  input  logic                                 ser_data,
  input  logic                                 ser_le,
  input  logic                                 chip_en,
  output logic [NUM_REGS*(WORD_W-ADDR_W)-1:0]  cfg_regs,
  output logic [NUM_REGS-1:0]                  upd_strobe,
  output logic                                 pump_hiz
);
  localparam int PAY_W = WORD_W - ADDR_W;

  logic [N_CHAN-1:0] raw_in;
  logic [N_CHAN-1:0] syn_in;
  logic              sclk_q;
  logic              le_q;
  logic              sclk_rise;
  logic              le_rise;
  logic              en_s;
  logic [WORD_W-1:0] shift_word;

  assign raw_in[CH_DATA] = ser_data;
  assign raw_in[CH_SCLK] = ser_clk;
  assign raw_in[CH_LE]   = ser_le;
  assign raw_in[CH_EN]   = chip_en;

  cfgl_sync #(
    .WIDTH  (N_CHAN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_in),
    .d_sync  (syn_in)
  );

  assign en_s = syn_in[CH_EN];

  // Edge detection in the system clock domain.
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      le_q     <= 1'b0;
      pump_hiz <= 1'b1;
    end else begin
      sclk_q   <= syn_in[CH_SCLK];
      le_q     <= syn_in[CH_LE];
      pump_hiz <= ~en_s;
    end
  end

  assign sclk_rise = syn_in[CH_SCLK] & ~sclk_q & en_s;
  assign le_rise   = syn_in[CH_LE] & ~le_q & en_s;

  cfgl_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clear    (~en_s),
    .shift_en (sclk_rise),
    .bit_in   (syn_in[CH_DATA]),
    .word     (shift_word)
  );

  cfgl_regbank #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .PAY_W    (PAY_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .clear     (~en_s),
    .load      (le_rise),
    .addr      (shift_word[ADDR_W-1:0]),
    .payload   (shift_word[WORD_W-1:ADDR_W]),
    .regs_flat (cfg_regs),
    .strobe    (upd_strobe)
  );
endmodule

// File: rtl/serial_cfg_loader_sva.sv
module cfgl_checker #(
  parameter int NREG = 8,
  parameter int PW   = 29
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NREG*PW-1:0]   cfg_regs,
  input logic [NREG-1:0]      upd_strobe,
  input logic                 pump_hiz
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_strobe));                                               // R4

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (|upd_strobe) |=> ((upd_strobe & $past(upd_strobe)) == '0));         // R4

  AST_POWERDOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
    pump_hiz |-> (cfg_regs == '0 && upd_strobe == '0));                  // R7

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe == '0 && !pump_hiz) |-> $stable(cfg_regs));              // R8
endmodule

bind serial_cfg_loader cfgl_checker #(
  .NREG (NUM_REGS),
  .PW   (WORD_W - ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_regs   (cfg_regs),
  .upd_strobe (upd_strobe),
  .pump_hiz   (pump_hiz)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  localparam int WW = 32;
  localparam int AW = 3;
  localparam int NR = 6;
  localparam int PW = WW - AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_data = 1'b0;
  logic ser_le = 1'b0;
  logic chip_en = 1'b0;
  logic [NR*PW-1:0] cfg_regs;
  logic [NR-1:0]    upd_strobe;
  logic             pump_hiz;

  serial_cfg_loader #(
    .WORD_W      (WW),
    .ADDR_W      (AW),
    .NUM_REGS    (NR),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .ser_le     (ser_le),
    .chip_en    (chip_en),
    .cfg_regs   (cfg_regs),
    .upd_strobe (upd_strobe),
    .pump_hiz   (pump_hiz)
  );

  always #2 clk = ~clk;  // 250 MHz

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference model state
  logic [PW-1:0] exp_reg [NR];
  logic [WW-1:0] shadow = '0;
  int            exp_cnt [NR];
  bit            en_model = 1'b0;

  // Strobe monitor
  int            stb_cnt [NR];
  int            stb_long  = 0;
  int            stb_multi = 0;
  logic [NR-1:0] stb_prev  = '0;

  initial begin
    for (int i = 0; i < NR; i++) begin
      exp_reg[i] = '0;
      exp_cnt[i] = 0;
      stb_cnt[i] = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NR; i++) if (upd_strobe[i]) stb_cnt[i]++;
      if ((upd_strobe & stb_prev) != '0) stb_long++;
      if ($countones(upd_strobe) > 1) stb_multi++;
      stb_prev = upd_strobe;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NR; i++) begin
      check(req, $sformatf("reg%0d", i), 64'(cfg_regs[i*PW +: PW]), 64'(exp_reg[i]));
      check(req, $sformatf("strobe count %0d", i), 64'(stb_cnt[i]), 64'(exp_cnt[i]));
    end
    check(req, "strobe wider than one cycle", 64'(stb_long), 64'd0);
    check(req, "several strobes at once", 64'(stb_multi), 64'd0);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) ser_data = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (8) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    if (en_model) shadow = {shadow[WW-2:0], b};
  endtask

  task automatic send_bits(input int n, input logic [63:0] v);
    for (int k = n - 1; k >= 0; k--) send_bit(v[k]);
  endtask

  task automatic pulse_le(input int hold);
    logic [AW-1:0] a;
    @(negedge clk) ser_le = 1'b1;
    repeat (hold) @(negedge clk);
    ser_le = 1'b0;
    repeat (10) @(negedge clk);
    if (en_model) begin
      a = shadow[AW-1:0];
      if (int'(a) < NR) begin
        exp_reg[a] = shadow[WW-1:AW];
        exp_cnt[a]++;
      end
    end
  endtask

  task automatic write_word(input logic [PW-1:0] pay, input logic [AW-1:0] a);
    send_bits(WW, 64'({pay, a}));
    pulse_le(8);
  endtask

  task automatic set_enable(input bit e);
    @(negedge clk) chip_en = e;
    repeat (8) @(negedge clk);
    en_model = e;
    if (!e) begin
      shadow = '0;
      for (int i = 0; i < NR; i++) exp_reg[i] = '0;
    end
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_all("R1");
    check("R1", "pump_hiz after reset", 64'(pump_hiz), 64'd1);

    set_enable(1'b1);
    check("R7", "pump_hiz when enabled", 64'(pump_hiz), 64'd0);

    // R2 / R4: directed word into register 2
    write_word(29'h1ABC_DEF0, 3'd2);
    check_all("R2");

    // R8: write every valid register; the others keep their values
    for (int i = 0; i < NR; i++) begin
      write_word(PW'(32'h0F0F_0000 + 32'(i) * 32'h1111), AW'(i));
      check_all("R8");
    end

    // R6: out-of-range addresses are dropped
    write_word(29'h0BAD_BEEF, 3'd6);
    check_all("R6");
    write_word(29'h1FFF_FFFF, 3'd7);
    check_all("R6");

    // R3: long load-enable high gives a single load
    send_bits(WW, 64'({29'h0123_4567, 3'd4}));
    pulse_le(60);
    check_all("R3");

    // R5: extra leading bits are discarded, short bursts reuse old bits
    send_bits(40, 64'hA5_1357_9BDF);
    pulse_le(8);
    check_all("R5");
    send_bits(10, 64'h2C1);
    pulse_le(8);
    check_all("R5");

    // R5 / R2: random burst lengths and contents
    for (int t = 0; t < 40; t++) begin
      int unsigned len;
      logic [63:0] v;
      len = 24 + ($urandom % 17);
      v = {$urandom, $urandom};
      send_bits(int'(len), v);
      pulse_le(4 + int'($urandom % 8));
      check_all("R5");
    end

    // R7: power-down clears and ignores traffic
    set_enable(1'b0);
    check_all("R7");
    check("R7", "pump_hiz in power-down", 64'(pump_hiz), 64'd1);
    write_word(29'h1234_5678, 3'd1);
    check_all("R7");
    set_enable(1'b1);
    check("R7", "pump_hiz after re-enable", 64'(pump_hiz), 64'd0);
    send_bits(8, 64'hF9);   // upper bits must come from a cleared shifter
    pulse_le(8);
    check_all("R7");
    check("R7", "reg1 after short write", 64'(cfg_regs[1*PW +: PW]), 64'h1F);

    finish_run();
  end
endmodule